// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master. A host programs it through a small 32-bit register port, and it then sends one management frame at a time on MDC/MDIO. Both the legacy frame format and the extended frame format are supported. A mode bit picks the format. The same two-bit access code is read differently in each format. In extended format, the write-data register supplies the 16-bit register address during an address frame.

The host sets up the mode, the port/device selection and the write data. It then writes the command register with the start bit set. A busy flag stays readable until the frame's last MDC period has finished. For read frames, the master releases MDIO from the turnaround bits onward and shifts in 16 bits from the PHY. An extended-format read takes two commands: an address command, then a read command issued once busy is low again.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads 0, MDC is low, the MDIO output enable is low and the MDIO output is high.
- R2: The register fields are at these places; unlisted bits read 0 and unmapped offsets read 0:
  - 0x40: mode bit 8 (1 = extended format).
  - 0x44: port address in bits 12:8 and register/device number in bits 4:0.
  - 0x48: write data in bits 15:0.
  - 0x4C: read data in bits 15:0.
  - 0x50: command, with access code in bits 1:0, start in bit 8 (write only) and busy in bit 31 (read only).
- R3: A command write with bit 8 set, made while idle, raises busy from the next cycle. Busy stays high for 64 MDC periods (128·DIV clocks) and then falls with MDC low.
- R4: MDC has a period of 2·DIV clocks and is low for the first DIV clocks of each bit. MDIO changes only where MDC falls, never while MDC is high.
- R5: Every frame starts with 32 ones. The legacy start field is 01. The legacy opcode is 10 for code bit0 = 0 (read) and 01 for code bit0 = 1 (write).
- R6: The extended start field is 00. Code 0 sends opcode 00 (address), code 1 sends 01 (write), and codes 2 and 3 send 11 (read). An address frame carries the write-data register as its 16-bit payload.
- R7: After the opcode, each frame sends the 5-bit port address and then the 5-bit register/device number, MSB first. Non-read frames then send turnaround 10 and the 16-bit write data, MSB first.
- R8: Read frames drop the output enable from bit 46 (the first turnaround bit) to the end. The master samples MDIO at each MDC rise during bits 48..63, MSB first, and loads the read-data register when the frame ends.
- R9: A command write made while busy is ignored: no new frame starts and the stored access code does not change.
- R10: The read-data register keeps its value through non-read frames and register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A wrong bit counter or a wrong shift position changes the MDIO or MDC level at the ports within one MDC period. Comparing every clock against a cycle-count model therefore catches such a fault in the same bit where it appears. A wrong release point for the output enable shows up at bit 46 of a read frame. A wrong capture order or a missing load of the read data shows up only when the read-data register is read after the frame ends. A command that should have been ignored but was not shows up as busy or MDC activity that differs from the model, either at once or at the expected end of the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_FIRST   = 46;
  localparam int unsigned DATA_FIRST = 48;

  localparam logic [7:0] OFF_MODE  = 8'h40;
  localparam logic [7:0] OFF_ADDR  = 8'h44;
  localparam logic [7:0] OFF_WDATA = 8'h48;
  localparam logic [7:0] OFF_RDATA = 8'h4C;
  localparam logic [7:0] OFF_CMD   = 8'h50;

  typedef struct packed {
    logic        ext;
    logic [1:0]  code;
    logic [4:0]  port;
    logic [4:0]  sel;
    logic [15:0] wdata;
  } mdio_req_t;

  function automatic logic req_is_read(mdio_req_t r);
    return r.ext ? r.code[1] : ~r.code[0];
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
    logic [1:0] st, op, ta;
    logic [15:0] pay;
    st  = r.ext ? 2'b00 : 2'b01;
    op  = r.ext ? {r.code[1], r.code[1] | r.code[0]} : (r.code[0] ? 2'b01 : 2'b10);
    ta  = req_is_read(r) ? 2'b11 : 2'b10;
    pay = req_is_read(r) ? 16'hFFFF : r.wdata;
    return {32'hFFFF_FFFF, st, op, r.port, r.sel, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        busy_i,
  input  logic        rd_valid_i,
  input  logic [15:0] rd_data_i,
  output logic        start_o,
  output mdio_req_t   req_o,
  output logic [1:0]  code_o,
  output logic [15:0] rdq_o
);
  logic        ext_q;
  logic [4:0]  port_q, sel_q;
  logic [15:0] wd_q, rd_q;
  logic [1:0]  code_q;
  logic        cmd_we;

  assign cmd_we  = we_i && (addr_i == OFF_CMD) && !busy_i;
  assign start_o = cmd_we && wdata_i[8];
  assign req_o   = '{ext: ext_q, code: wdata_i[1:0], port: port_q, sel: sel_q, wdata: wd_q};
  assign code_o  = code_q;
  assign rdq_o   = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b0;
      port_q <= '0;
      sel_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      code_q <= '0;
    end else begin
      if (we_i && addr_i == OFF_MODE) ext_q <= wdata_i[8];
      if (we_i && addr_i == OFF_ADDR) begin
        port_q <= wdata_i[12:8];
        sel_q  <= wdata_i[4:0];
      end
      if (we_i && addr_i == OFF_WDATA) wd_q <= wdata_i[15:0];
      if (cmd_we) code_q <= wdata_i[1:0];
      if (rd_valid_i) rd_q <= rd_data_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_MODE:  rdata_o = {23'b0, ext_q, 8'b0};
      OFF_ADDR:  rdata_o = {19'b0, port_q, 3'b0, sel_q};
      OFF_WDATA: rdata_o = {16'b0, wd_q};
      OFF_RDATA: rdata_o = {16'b0, rd_q};
      OFF_CMD:   rdata_o = {busy_i, 29'b0, code_q};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_bitclk.sv
module mdio_bitclk #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned PERIOD = 2 * DIV;
  localparam int unsigned CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign rise_o = run_i && (cnt_q == CW'(DIV - 1));
  assign fall_o = run_i && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (fall_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  mdio_req_t   req_i,
  output logic        busy_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i,
  output logic        rd_valid_o,
  output logic [15:0] rd_data_o
);
  localparam int unsigned IW = $clog2(FRAME_BITS);

  logic                  busy_q, mdc_q, mdo_q, oe_q, rd_q, rdv_q;
  logic [FRAME_BITS-1:0] sh_q, frame;
  logic [IW-1:0]         idx_q, idx_nxt;
  logic [15:0]           cap_q;
  logic                  rise, fall;

  mdio_bitclk #(.DIV(DIV)) u_bitclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign frame   = build_frame(req_i);
  assign idx_nxt = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      rdv_q  <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
    end else begin
      rdv_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sh_q   <= frame;
          rd_q   <= req_is_read(req_i);
          idx_q  <= '0;
          mdc_q  <= 1'b0;
          mdo_q  <= frame[FRAME_BITS-1];
          oe_q   <= 1'b1;
        end
      end else begin
        if (rise) begin
          mdc_q <= 1'b1;
          if (idx_q >= IW'(DATA_FIRST)) cap_q <= {cap_q[14:0], mdio_i};
        end
        if (fall) begin
          mdc_q <= 1'b0;
          if (idx_q == IW'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            mdo_q  <= 1'b1;
            rdv_q  <= rd_q;
          end else begin
            idx_q <= idx_nxt;
            sh_q  <= sh_q << 1;
            mdo_q <= sh_q[FRAME_BITS-2];
            oe_q  <= !(rd_q && idx_nxt >= IW'(TA_FIRST));
          end
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign mdc_o      = mdc_q;
  assign mdio_o     = mdo_q;
  assign mdio_oe_o  = oe_q;
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = cap_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        start, busy, rd_valid;
  logic [15:0] rd_data, rdata_q;
  logic [1:0]  code;
  mdio_req_t   req;

  mdio_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .rd_valid_i (rd_valid),
    .rd_data_i  (rd_data),
    .start_o    (start),
    .req_o      (req),
    .code_o     (code),
    .rdq_o      (rdata_q)
  );

  mdio_engine #(.DIV(DIV)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .req_i      (req),
    .busy_o     (busy),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .mdio_i     (mdio_i),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  reg_addr_i,
  input logic        reg_we_i,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        start,
  input logic        busy,
  input logic        rd_valid,
  input logic [1:0]  code,
  input logic [15:0] rdata_q
);
  assert_mdc_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
  assert_mdio_steady_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o));
  assert_oe_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy);
  assert_load_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid |-> !busy);
  assert_busy_cmd_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && reg_addr_i == OFF_CMD) |=> ($stable(code) && busy));
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid |=> $stable(rdata_q));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o),
  .start      (start),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .code       (code),
  .rdata_q    (rdata_q)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DIV = 4;
  localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WD = 8'h48, A_RD = 8'h4C, A_CMD = 8'h50;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = A_CMD;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mdc, mdo, mdoe;
  logic        mdi = 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mdio_master #(.DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  // reference model state
  bit          m_ext = 0, m_busy = 0, m_rd = 0;
  logic [4:0]  m_port = 0, m_sel = 0;
  logic [15:0] m_wd = 0, m_rdata = 0, m_reply = 0;
  logic [1:0]  m_code = 0;
  logic [63:0] m_frame = 0;
  int          m_n = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_frame();
    logic [1:0] st, op;
    bit rd;
    st = m_ext ? 2'b00 : 2'b01;
    if (!m_ext) op = m_code[0] ? 2'b01 : 2'b10;
    else case (m_code)
      2'd0: op = 2'b00;
      2'd1: op = 2'b01;
      default: op = 2'b11;
    endcase
    rd = m_ext ? m_code[1] : !m_code[0];
    return {{32{1'b1}}, st, op, m_port, m_sel, rd ? 2'b11 : 2'b10, m_wd};
  endfunction

  task automatic model_edge();
    bit was_busy = m_busy;
    if (reg_we) begin
      if (reg_addr == A_MODE) m_ext = reg_wdata[8];
      if (reg_addr == A_ADDR) begin m_port = reg_wdata[12:8]; m_sel = reg_wdata[4:0]; end
      if (reg_addr == A_WD) m_wd = reg_wdata[15:0];
      if (reg_addr == A_CMD && !was_busy) m_code = reg_wdata[1:0];
    end
    if (was_busy) begin
      m_n++;
      if (m_n == 128 * DIV) begin
        m_busy = 0;
        if (m_rd) m_rdata = m_reply;
      end
    end else if (reg_we && reg_addr == A_CMD && reg_wdata[8]) begin
      m_busy = 1; m_n = 0;
      m_frame = ref_frame();
      m_rd = m_ext ? m_code[1] : !m_code[0];
    end
  endtask

  task automatic compare();
    int b = m_n / (2 * DIV);
    int ph = m_n % (2 * DIV);
    if (m_busy) begin
      check("R4 mdc", 32'(mdc), 32'(ph >= DIV));
      check("R8 oe", 32'(mdoe), 32'(!(m_rd && b >= 46)));
      if (!(m_rd && b >= 46)) check("R5/R6/R7 mdio bit", 32'(mdo), 32'(m_frame[63 - b]));
      if (m_rd && b == 47) mdi = 1'b0;
      else if (m_rd && b >= 48) mdi = m_reply[63 - b];
      else mdi = 1'b1;
    end else begin
      check("R3 idle mdc", 32'(mdc), 0);
      check("R3 idle oe", 32'(mdoe), 0);
      mdi = 1'b1;
    end
    if (reg_addr == A_CMD) check("R3 busy flag", 32'(reg_rdata[31]), 32'(m_busy));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    step();
    reg_we = 0; reg_addr = A_CMD;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
    reg_addr = A_CMD;
  endtask

  task automatic wait_idle();
    while (m_busy) step();
    step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 addr", A_ADDR, 0);
    rd_chk("R1 wdata", A_WD, 0);
    rd_chk("R1 rdata", A_RD, 0);
    rd_chk("R1 cmd", A_CMD, 0);
    check("R1 mdc", 32'(mdc), 0);
    check("R1 oe", 32'(mdoe), 0);
    check("R1 mdio", 32'(mdo), 1);
    step();

    // R2 field placement
    wr(A_ADDR, 32'hFFFF_FFFF); rd_chk("R2 addr fields", A_ADDR, 32'h0000_1F1F);
    wr(A_MODE, 32'hFFFF_FFFF); rd_chk("R2 mode bit", A_MODE, 32'h0000_0100);
    wr(A_WD, 32'hFFFF_FFFF);   rd_chk("R2 wdata field", A_WD, 32'h0000_FFFF);
    rd_chk("R2 unmapped", 8'h60, 0);
    wr(A_MODE, 0);

    // R5 R7 legacy write
    wr(A_ADDR, 32'h0000_0503);
    wr(A_WD, 32'h0000_A5C3);
    wr(A_CMD, 32'h0000_0101);
    rd_chk("R2 cmd code", A_CMD, 32'h8000_0001);
    wait_idle();
    rd_chk("R10 rdata after write", A_RD, 0);

    // R8 legacy read with ignored command R9 mid-frame
    wr(A_ADDR, 32'h0000_0102);
    m_reply = 16'h1234;
    wr(A_CMD, 32'h0000_0100);
    repeat (60) step();
    wr(A_CMD, 32'h0000_0103);
    wait_idle();
    rd_chk("R8 legacy read data", A_RD, 32'h0000_1234);
    rd_chk("R9 code unchanged", A_CMD, 32'h0000_0000);

    // R6 extended address frame, then read and write
    wr(A_MODE, 32'h0000_0100);
    wr(A_ADDR, 32'h0000_0307);
    wr(A_WD, 32'h0000_BEEF);
    wr(A_CMD, 32'h0000_0100);
    wait_idle();
    rd_chk("R10 rdata after ext address", A_RD, 32'h0000_1234);
    m_reply = 16'hCAFE;
    wr(A_CMD, 32'h0000_0102);
    wait_idle();
    rd_chk("R8 ext read data", A_RD, 32'h0000_CAFE);
    wr(A_WD, 32'h0000_0F0F);
    wr(A_CMD, 32'h0000_0101);
    wait_idle();
    rd_chk("R10 rdata after ext write", A_RD, 32'h0000_CAFE);
    m_reply = 16'h8001;
    wr(A_CMD, 32'h0000_0103);
    wait_idle();
    rd_chk("R6 code 3 reads", A_RD, 32'h0000_8001);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule